// File: doc/BRIEF.md
# Serial-In Latched Display Driver Logic

This block is the digital core of a display driver channel bank. Data arrives one bit per clock on a serial input and moves through a shift register. A level-sensitive strobe copies the register into a bank of transparent latches. Each latch bit controls one output channel. A channel has two enables, one for the high-side source driver and one for the active pull-down sink. A blanking input turns every channel to its pull-down state without touching the stored data.

The last stage of the register appears on a serial output. Several blocks can therefore be chained on a shared clock, strobe and blanking line to drive longer digit or segment rows. The register length is the parameter `W`, which defaults to 10.

Top module: `serial_latch_driver`

## Requirements
- R1: While `rst_n` is low (asynchronous, active low), the shift register and the latches are all zeros, every `src_en` bit is 0 and every `snk_en` bit is 1.
- R2: On each rising `clk` edge, stage 0 (the stage nearest `ser_in`, which drives channel bit 0) captures `ser_in`.
- R3: On each rising `clk` edge, every stage k>0 takes the value of stage k-1. `ser_out` always equals stage W-1.
- R4: While `strobe` is high, every latch follows its shift stage continuously, including across shift edges.
- R5: While `strobe` is low, the latches keep their value and the channel outputs ignore shifting.
- R6: While `blank` is high, `src_en` is all zeros and `snk_en` is all ones, whatever the latches hold. This also holds with `strobe` high during serial entry.
- R7: `blank` never alters the latches. When `blank` falls, each channel again shows its latch, as last loaded.
- R8: With `blank` low, channel i drives `src_en[i]=latch[i]` and `snk_en[i]=~latch[i]`.
- R9: No channel ever has `src_en` and `snk_en` both 1.
- R10: Two blocks chained through `ser_out` to `ser_in` act as one 2W-bit register. The first bit shifted in ends in the far block's top stage.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Shift clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_in | input | 1 | Serial data into stage 0 |
| strobe | input | 1 | Latch enable, transparent while high |
| blank | input | 1 | Forces all channels to pull-down while high |
| src_en | output | W | Per-channel source driver enable |
| snk_en | output | W | Per-channel pull-down sink enable |
| ser_out | output | 1 | Last shift stage, for cascading |

## Verification
The shift stages and `ser_out` change at a rising edge and are due one edge after `ser_in` is applied. The latch and blanking paths have no register, so the channel outputs follow `strobe` and `blank` in the same cycle. When `strobe` is high, they also follow the shift data just after the edge. Inputs are driven on the falling edge, and the bench model advances at the rising edge. Every output is compared at the next falling edge, half a period after the edge that could change it. This makes one-edge results and zero-latency results land on the same sample.

// File: rtl/sdrv_pkg.sv
package sdrv_pkg;
  // Returns {source_enable, sink_enable} for one channel.
  function automatic logic [1:0] chan_drive(input logic lat, input logic blank);
    logic [1:0] r;
    if (blank) r = 2'b01;
    else       r = {lat, ~lat};
    return r;
  endfunction
endpackage

// File: rtl/sdrv_shift.sv
module sdrv_shift #(
  parameter int W = 10
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         din,
  output logic [W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= {q[W-2:0], din};
  end
endmodule

// File: rtl/sdrv_latch.sv
module sdrv_latch #(
  parameter int W = 10
) (
  input  logic         rst_n,
  input  logic         en,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_latch begin
    if (!rst_n)  q = '0;
    else if (en) q = d;
  end
endmodule

// File: rtl/sdrv_out.sv
module sdrv_out #(
  parameter int W = 10
) (
  input  logic [W-1:0] lat,
  input  logic         blank,
  output logic [W-1:0] src_en,
  output logic [W-1:0] snk_en
);
  import sdrv_pkg::*;
  for (genvar i = 0; i < W; i++) begin : g_chan
    logic [1:0] drv;
    assign drv       = chan_drive(lat[i], blank);
    assign src_en[i] = drv[1];
    assign snk_en[i] = drv[0];
  end
endmodule

// File: rtl/serial_latch_driver.sv
module serial_latch_driver #(
  parameter int W = 10
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ser_in,
  input  logic         strobe,
  input  logic         blank,
  output logic [W-1:0] src_en,
  output logic [W-1:0] snk_en,
  output logic         ser_out
);
  logic [W-1:0] shift_q;
  logic [W-1:0] latch_q;

  sdrv_shift #(.W(W)) u_shift (
    .clk(clk), .rst_n(rst_n), .din(ser_in), .q(shift_q)
  );

  sdrv_latch #(.W(W)) u_latch (
    .rst_n(rst_n), .en(strobe), .d(shift_q), .q(latch_q)
  );

  sdrv_out #(.W(W)) u_out (
    .lat(latch_q), .blank(blank), .src_en(src_en), .snk_en(snk_en)
  );

  assign ser_out = shift_q[W-1];
endmodule

// File: rtl/sdrv_checker.sv
module sdrv_checker #(
  parameter int W = 10
) (
  input logic         clk,
  input logic         rst_n,
  input logic         ser_in,
  input logic         strobe,
  input logic         blank,
  input logic [W-1:0] src_en,
  input logic [W-1:0] snk_en,
  input logic         ser_out,
  input logic [W-1:0] shift_q,
  input logic [W-1:0] latch_q
);
  assert_capture_R2: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> shift_q[0] == $past(ser_in));

  assert_shift_R3: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> shift_q[W-1:1] == $past(shift_q[W-2:0]));

  assert_serout_R3: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ser_out == $past(shift_q[W-2]));

  assert_transparent_R4: assert property (@(posedge clk) disable iff (!rst_n)
    strobe |-> latch_q == shift_q);

  assert_blank_R6: assert property (@(posedge clk) disable iff (!rst_n)
    blank |-> (src_en == '0 && snk_en == '1));

  assert_map_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !blank |-> (src_en == latch_q && snk_en == ~latch_q));

  assert_exclusive_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (src_en & snk_en) == '0);
endmodule

bind serial_latch_driver sdrv_checker #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .ser_in(ser_in), .strobe(strobe), .blank(blank),
  .src_en(src_en), .snk_en(snk_en), .ser_out(ser_out),
  .shift_q(shift_q), .latch_q(latch_q)
);

// File: tb/serial_latch_driver_test.sv
module serial_latch_driver_test;
  localparam int W = 10;
  localparam time CLK_PERIOD = 10ns;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic din = 1'b0, stb = 1'b0, blk = 1'b0;
  logic [W-1:0] src_a, snk_a, src_b, snk_b;
  logic so_a, so_b;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  logic [2*W-1:0] m_shift = '0;
  logic [2*W-1:0] m_lat = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  serial_latch_driver #(.W(W)) uut (
    .clk(clk), .rst_n(rst_n), .ser_in(din), .strobe(stb), .blank(blk),
    .src_en(src_a), .snk_en(snk_a), .ser_out(so_a)
  );

  serial_latch_driver #(.W(W)) uut_b (
    .clk(clk), .rst_n(rst_n), .ser_in(so_a), .strobe(stb), .blank(blk),
    .src_en(src_b), .snk_en(snk_b), .ser_out(so_b)
  );

  function automatic logic [W-1:0] want_src(input logic [W-1:0] l, input logic b);
    return b ? '0 : l;
  endfunction

  function automatic logic [W-1:0] want_snk(input logic [W-1:0] l, input logic b);
    return b ? '1 : ~l;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // Compare all outputs of both devices with the model.
  task automatic compare(input string tag);
    logic [W-1:0] la, lb;
    la = m_lat[W-1:0];
    lb = m_lat[2*W-1:W];
    chk(src_a == want_src(la, blk), tag, 32'(src_a), 32'(want_src(la, blk)));
    chk(snk_a == want_snk(la, blk), tag, 32'(snk_a), 32'(want_snk(la, blk)));
    chk(src_b == want_src(lb, blk), {tag, "/R10"}, 32'(src_b), 32'(want_src(lb, blk)));
    chk(snk_b == want_snk(lb, blk), {tag, "/R10"}, 32'(snk_b), 32'(want_snk(lb, blk)));
    chk(so_a == m_shift[W-1], "R3 ser_out", 32'(so_a), 32'(m_shift[W-1]));
    chk(so_b == m_shift[2*W-1], "R10 ser_out", 32'(so_b), 32'(m_shift[2*W-1]));
    chk(((src_a & snk_a) == '0) && ((src_b & snk_b) == '0), "R9 exclusive",
        32'({src_b & snk_b, src_a & snk_a}), 32'd0);
  endtask

  // Check the current state, then apply new inputs for one clock.
  task automatic step(input logic d, input logic s, input logic b, input string tag);
    @(negedge clk);
    compare(tag);
    din = d; stb = s; blk = b;
    if (s) m_lat = m_shift;
    @(posedge clk);
    m_shift = {m_shift[2*W-2:0], d};
    if (s) m_lat = m_shift;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [2*W-1:0] pat;
    void'($urandom(32'd20240611));
    // R1: reset state
    #(CLK_PERIOD * 3);
    compare("R1 reset");
    @(negedge clk);
    rst_n = 1'b1;

    // R2/R3/R5: shift a pattern with strobe low; outputs stay pull-down
    pat = 20'hA5C3B;
    for (int i = 2*W-1; i >= 0; i--) step(pat[i], 1'b0, 1'b0, "R5 hold while shifting");
    // R4/R8: strobe pulse loads latches
    step(1'b0, 1'b1, 1'b0, "R4 strobe load");
    step(1'b1, 1'b0, 1'b0, "R8 mapping");
    step(1'b0, 1'b0, 1'b0, "R5 hold");

    // R7: blank with strobe low, then release shows old data
    for (int i = 0; i < 5; i++) step(1'($urandom), 1'b0, 1'b1, "R6 blank");
    step(1'b0, 1'b0, 1'b0, "R7 release");
    step(1'b0, 1'b0, 1'b0, "R7 restored");

    // R6: strobe held high during entry with blank high
    for (int i = 0; i < 2*W; i++) step(1'($urandom), 1'b1, 1'b1, "R6 entry blanked");
    step(1'b0, 1'b0, 1'b0, "R7 unblank after entry");
    step(1'b0, 1'b0, 1'b0, "R8 after entry");

    // R4: transparent ripple with blank low
    for (int i = 0; i < 8; i++) step(1'($urandom), 1'b1, 1'b0, "R4 ripple");

    // Random mix
    for (int i = 0; i < 400; i++)
      step(1'($urandom), ($urandom % 4) == 0, ($urandom % 5) == 0, "R8 random");

    // R1: asynchronous reset in mid-run
    @(negedge clk);
    #(CLK_PERIOD/4) rst_n = 1'b0;
    m_shift = '0; m_lat = '0; blk = 1'b0; stb = 1'b0;
    #1;
    compare("R1 async reset");
    @(negedge clk);
    compare("R1 reset held");

    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule